// File: doc/BRIEF.md
# Cache-Block Operation Permission Checker

This block decides whether a cache-block management request may run at the current privilege level. The request classes are clean, flush, invalidate and zero. Three environment-configuration registers hold the enables: one for the machine level, one for the supervisor level and one for the hypervisor level. Each register has three fields: a clean/flush enable, a two-bit invalidate enable and a zero enable.

A request names the privilege mode, whether the hart runs virtualized, and the operation class. The block compares the request with the enable fields that govern it. One clock edge later it returns exactly one of three verdicts: allow, illegal-instruction trap or virtual-instruction trap. For an allowed invalidate it also says whether the operation must be carried out as a flush, that is a clean followed by an invalidate.

The configuration registers are written and read through a small register port. Two parameters state whether the management operations and the zero operation are implemented. Fields that belong to an operation that is not implemented cannot be written and always read as zero. Memory access, address translation and cache state lie outside this block.

Top module: `cmo_perm_unit`

## Requirements
- R1: After reset every configuration field reads as zero, and rsp_valid_o, rsp_allow_o, rsp_illegal_o, rsp_virtual_o and rsp_as_flush_o are all low.
- R2: A write with cfg_wr_en_i high stores cfg_wr_data_i at the clock edge into the register that cfg_wr_sel_i selects (0 machine, 1 supervisor, 2 hypervisor). The data layout is bit 0 clean/flush enable, bits 2:1 invalidate enable and bit 3 zero enable. cfg_rd_data_o shows the register that cfg_rd_sel_i selects, combinationally. Select value 3 reads as zero and a write to it changes nothing.
- R3: With MGMT_EN=0, bits 2:0 can never be written and always read as zero. With ZERO_EN=0, bit 3 can never be written and always reads as zero.
- R4: A request sampled with req_valid_i high at a clock edge produces rsp_valid_o high after that edge, with exactly one of allow, illegal or virtual high. When req_valid_i was low, all five response outputs are low after the edge.
- R5: Operation codes are 0 clean, 1 flush, 2 invalidate and 3 zero. Clean and flush are governed by the clean/flush field, invalidate by the invalidate field and zero by the zero field. A field counts as off when it is zero.
- R6: Machine mode (req_priv_i = 3) is always allowed, whatever the fields and req_virt_i are, and never asks for a flush.
- R7: An illegal-instruction trap is raised when the mode is not machine and the machine-level field is off. It is also raised when the mode is user (0), req_virt_i is low and the supervisor-level field is off.
- R8: If no illegal trap applies, a virtual-instruction trap is raised when req_virt_i is high, the mode is not machine, and either the hypervisor-level field is off or the mode is user and the supervisor-level field is off.
- R9: When the conditions for both traps hold, only rsp_illegal_o is raised.
- R10: For an allowed invalidate, rsp_as_flush_o is high when any governing level holds invalidate field value 01. The machine level governs outside machine mode, the supervisor level governs in user mode, and the hypervisor level governs when virtualized. Values 10 and 11 give a pure invalidate. rsp_as_flush_o is low for other operations and for trapped requests.
- R11: The reserved privilege code 2 is treated as supervisor mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en_i | input | 1 | Configuration write strobe |
| cfg_wr_sel_i | input | 2 | Register select for writes: 0 machine, 1 supervisor, 2 hypervisor |
| cfg_wr_data_i | input | 4 | Write data: bit 0 clean/flush, bits 2:1 invalidate, bit 3 zero |
| cfg_rd_sel_i | input | 2 | Register select for reads |
| cfg_rd_data_o | output | 4 | Selected register, masked by the implemented features |
| req_valid_i | input | 1 | Request present this cycle |
| req_priv_i | input | 2 | Privilege mode: 0 user, 1 supervisor, 3 machine |
| req_virt_i | input | 1 | Request issued while virtualized |
| req_op_i | input | 2 | Operation class: 0 clean, 1 flush, 2 invalidate, 3 zero |
| rsp_valid_o | output | 1 | Verdict present |
| rsp_allow_o | output | 1 | Operation may run |
| rsp_illegal_o | output | 1 | Raise illegal-instruction trap |
| rsp_virtual_o | output | 1 | Raise virtual-instruction trap |
| rsp_as_flush_o | output | 1 | Run the allowed invalidate as a flush |

## Verification
A verdict is due one clock edge after the edge that samples the request. The bench model therefore computes the expected verdict at each rising edge from the inputs and its own copy of the configuration, and compares it with the outputs at the following falling edge, on every cycle, for three parameter variants at once. A configuration write counts from the edge that samples it. A request in the same cycle as a write is judged on the old value, and the model applies writes only after it has judged the request. The read port is combinational, so read-back is compared one time step after the select changes, inside the same low clock phase.

// File: rtl/cmo_perm_pkg.sv
package cmo_perm_pkg;

  // field widths of one configuration register
  localparam int CF_W   = 1;
  localparam int INV_W  = 2;
  localparam int ZR_W   = 1;
  localparam int CFG_W  = CF_W + INV_W + ZR_W;
  localparam int CF_LSB  = 0;
  localparam int INV_LSB = CF_LSB + CF_W;
  localparam int ZR_LSB  = INV_LSB + INV_W;

  // configuration levels
  localparam int NUM_LVL = 3;
  localparam int LVL_W   = 2;
  localparam int LVL_M   = 0;
  localparam int LVL_S   = 1;
  localparam int LVL_H   = 2;

  // invalidate field value that turns an invalidate into a flush
  localparam logic [INV_W-1:0] INV_AS_FLUSH = INV_W'(1);

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    OP_CLEAN = 2'd0,
    OP_FLUSH = 2'd1,
    OP_INVAL = 2'd2,
    OP_ZERO  = 2'd3
  } op_e;

  typedef struct packed {
    logic [ZR_W-1:0]  zr;
    logic [INV_W-1:0] inv;
    logic [CF_W-1:0]  cf;
  } envcfg_t;

  typedef struct packed {
    logic allow;
    logic illegal;
    logic virt_trap;
    logic as_flush;
  } verdict_t;

  // field that governs a given operation, widened to the invalidate width
  function automatic logic [INV_W-1:0] field_of(envcfg_t c, op_e op);
    logic [INV_W-1:0] f;
    unique case (op)
      OP_CLEAN, OP_FLUSH: f = INV_W'(c.cf);
      OP_INVAL:           f = c.inv;
      default:            f = INV_W'(c.zr);
    endcase
    return f;
  endfunction

endpackage

// File: rtl/cmo_rst_sync.sv
module cmo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/cmo_cfg_bank.sv
module cmo_cfg_bank
  import cmo_perm_pkg::*;
#(
  parameter bit MGMT_EN = 1'b1,
  parameter bit ZERO_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  output envcfg_t          cfg_o
);
  // writable bits follow the implemented operation groups
  localparam logic [CFG_W-1:0] WMASK =
    {{ZR_W{ZERO_EN}}, {INV_W{MGMT_EN}}, {CF_W{MGMT_EN}}};

  envcfg_t cfg_q;
  envcfg_t cfg_d;
  logic    cfg_en;

  always_comb begin
    cfg_en = wr_en_i;
    cfg_d  = envcfg_t'(wr_data_i & WMASK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/cmo_perm_eval.sv
module cmo_perm_eval
  import cmo_perm_pkg::*;
(
  input  logic     valid_i,
  input  logic [1:0] priv_i,
  input  logic     virt_i,
  input  logic [1:0] op_i,
  input  envcfg_t  cfg_m_i,
  input  envcfg_t  cfg_s_i,
  input  envcfg_t  cfg_h_i,
  output verdict_t verdict_o
);
  priv_e            priv;
  op_e              op;
  logic             is_m;
  logic             is_u;
  logic             virt_eff;
  logic [INV_W-1:0] fld_m;
  logic [INV_W-1:0] fld_s;
  logic [INV_W-1:0] fld_h;
  logic             on_m;
  logic             on_s;
  logic             on_h;
  logic             ill;
  logic             vtrap;
  logic             flush_req;

  always_comb begin
    priv     = priv_e'(priv_i);
    op       = op_e'(op_i);
    is_m     = (priv == PRIV_M);
    // reserved code behaves as supervisor: neither machine nor user
    is_u     = (priv == PRIV_U);
    virt_eff = virt_i && !is_m;

    fld_m = field_of(cfg_m_i, op);
    fld_s = field_of(cfg_s_i, op);
    fld_h = field_of(cfg_h_i, op);
    on_m  = |fld_m;
    on_s  = |fld_s;
    on_h  = |fld_h;

    // illegal checks first, virtual checks only when no illegal applies
    ill   = !is_m && (!on_m || (is_u && !virt_eff && !on_s));
    vtrap = !ill && virt_eff && (!on_h || (is_u && !on_s));

    flush_req = (!is_m    && (fld_m == INV_AS_FLUSH)) ||
                (is_u     && (fld_s == INV_AS_FLUSH)) ||
                (virt_eff && (fld_h == INV_AS_FLUSH));

    verdict_o.illegal   = valid_i && ill;
    verdict_o.virt_trap = valid_i && vtrap;
    verdict_o.allow     = valid_i && !ill && !vtrap;
    verdict_o.as_flush  = valid_i && !ill && !vtrap && (op == OP_INVAL) && flush_req;
  end
endmodule

// File: rtl/cmo_rsp_reg.sv
module cmo_rsp_reg
  import cmo_perm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     valid_i,
  input  verdict_t verdict_i,
  output logic     valid_o,
  output verdict_t verdict_o
);
  logic     valid_q;
  logic     valid_d;
  verdict_t verdict_q;
  verdict_t verdict_d;

  always_comb begin
    valid_d   = valid_i;
    verdict_d = valid_i ? verdict_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      verdict_q <= '0;
    end else begin
      valid_q   <= valid_d;
      verdict_q <= verdict_d;
    end
  end

  assign valid_o   = valid_q;
  assign verdict_o = verdict_q;
endmodule

// File: rtl/cmo_perm_unit.sv
module cmo_perm_unit
  import cmo_perm_pkg::*;
#(
  parameter bit MGMT_EN = 1'b1,
  parameter bit ZERO_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_wr_en_i,
  input  logic [LVL_W-1:0] cfg_wr_sel_i,
  input  logic [CFG_W-1:0] cfg_wr_data_i,
  input  logic [LVL_W-1:0] cfg_rd_sel_i,
  output logic [CFG_W-1:0] cfg_rd_data_o,
  input  logic             req_valid_i,
  input  logic [1:0]       req_priv_i,
  input  logic             req_virt_i,
  input  logic [1:0]       req_op_i,
  output logic             rsp_valid_o,
  output logic             rsp_allow_o,
  output logic             rsp_illegal_o,
  output logic             rsp_virtual_o,
  output logic             rsp_as_flush_o
);
  logic         rst_sync_n;
  logic [NUM_LVL-1:0] lvl_we;
  envcfg_t      cfg_q [NUM_LVL];
  envcfg_t      rd_mux;
  verdict_t     verdict_d;
  verdict_t     verdict_q;

  cmo_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    assign lvl_we[g] = cfg_wr_en_i && (cfg_wr_sel_i == LVL_W'(g));

    cmo_cfg_bank #(
      .MGMT_EN (MGMT_EN),
      .ZERO_EN (ZERO_EN)
    ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_sync_n),
      .wr_en_i   (lvl_we[g]),
      .wr_data_i (cfg_wr_data_i),
      .cfg_o     (cfg_q[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (cfg_rd_sel_i == LVL_W'(i)) rd_mux = cfg_q[i];
    end
  end
  assign cfg_rd_data_o = rd_mux;

  cmo_perm_eval u_eval (
    .valid_i   (req_valid_i),
    .priv_i    (req_priv_i),
    .virt_i    (req_virt_i),
    .op_i      (req_op_i),
    .cfg_m_i   (cfg_q[LVL_M]),
    .cfg_s_i   (cfg_q[LVL_S]),
    .cfg_h_i   (cfg_q[LVL_H]),
    .verdict_o (verdict_d)
  );

  cmo_rsp_reg u_rsp (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .valid_i   (req_valid_i),
    .verdict_i (verdict_d),
    .valid_o   (rsp_valid_o),
    .verdict_o (verdict_q)
  );

  assign rsp_allow_o    = verdict_q.allow;
  assign rsp_illegal_o  = verdict_q.illegal;
  assign rsp_virtual_o  = verdict_q.virt_trap;
  assign rsp_as_flush_o = verdict_q.as_flush;
endmodule

// File: rtl/cmo_perm_chk.sv
module cmo_perm_chk
  import cmo_perm_pkg::*;
#(
  parameter bit MGMT_EN = 1'b1,
  parameter bit ZERO_EN = 1'b1
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             req_valid_i,
  input logic [1:0]       req_priv_i,
  input logic [1:0]       req_op_i,
  input envcfg_t          cfg_m_i,
  input logic [CFG_W-1:0] cfg_rd_data_o,
  input logic             rsp_valid_o,
  input logic             rsp_allow_o,
  input logic             rsp_illegal_o,
  input logic             rsp_virtual_o,
  input logic             rsp_as_flush_o
);
  assert_one_verdict_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    rsp_valid_o |-> ($countones({rsp_allow_o, rsp_illegal_o, rsp_virtual_o}) == 1));

  assert_idle_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    !rsp_valid_o |-> !(rsp_allow_o || rsp_illegal_o || rsp_virtual_o || rsp_as_flush_o));

  assert_req_follow_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    req_valid_i |=> rsp_valid_o);

  assert_noreq_follow_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    !req_valid_i |=> !rsp_valid_o);

  assert_machine_allowed_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (req_valid_i && (req_priv_i == 2'd3)) |=> (rsp_allow_o && !rsp_as_flush_o));

  // also covers R9: a machine-level miss never turns into a virtual trap
  assert_machine_off_illegal_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (req_valid_i && (req_priv_i != 2'd3) && (field_of(cfg_m_i, op_e'(req_op_i)) == '0))
      |=> (rsp_illegal_o && !rsp_virtual_o));

  assert_flush_only_allowed_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    rsp_as_flush_o |-> rsp_allow_o);

  assert_zero_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    ZERO_EN || (cfg_rd_data_o[ZR_LSB] == 1'b0));

  assert_mgmt_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    MGMT_EN || (cfg_rd_data_o[ZR_LSB-1:0] == '0));
endmodule

bind cmo_perm_unit cmo_perm_chk #(
  .MGMT_EN (MGMT_EN),
  .ZERO_EN (ZERO_EN)
) u_chk (
  .clk_i          (clk_i),
  .rst_n          (rst_sync_n),
  .req_valid_i    (req_valid_i),
  .req_priv_i     (req_priv_i),
  .req_op_i       (req_op_i),
  .cfg_m_i        (cfg_q[0]),
  .cfg_rd_data_o  (cfg_rd_data_o),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_allow_o    (rsp_allow_o),
  .rsp_illegal_o  (rsp_illegal_o),
  .rsp_virtual_o  (rsp_virtual_o),
  .rsp_as_flush_o (rsp_as_flush_o)
);

// File: tb/cmo_perm_unit_tb.sv
`timescale 1ns/1ps
module cmo_perm_unit_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_ni;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [3:0] wr_data;
  logic [1:0] rd_sel;
  logic       req_valid;
  logic [1:0] req_priv;
  logic       req_virt;
  logic [1:0] req_op;

  logic [3:0] rd0, rd1, rd2;
  logic [2:0] rv, ra, ri, rt, rf;

  cmo_perm_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_wr_en_i(wr_en), .cfg_wr_sel_i(wr_sel),
    .cfg_wr_data_i(wr_data), .cfg_rd_sel_i(rd_sel), .cfg_rd_data_o(rd0),
    .req_valid_i(req_valid), .req_priv_i(req_priv), .req_virt_i(req_virt), .req_op_i(req_op),
    .rsp_valid_o(rv[0]), .rsp_allow_o(ra[0]), .rsp_illegal_o(ri[0]),
    .rsp_virtual_o(rt[0]), .rsp_as_flush_o(rf[0]));

  cmo_perm_unit #(.MGMT_EN(1'b1), .ZERO_EN(1'b0)) u_dut_nz (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_wr_en_i(wr_en), .cfg_wr_sel_i(wr_sel),
    .cfg_wr_data_i(wr_data), .cfg_rd_sel_i(rd_sel), .cfg_rd_data_o(rd1),
    .req_valid_i(req_valid), .req_priv_i(req_priv), .req_virt_i(req_virt), .req_op_i(req_op),
    .rsp_valid_o(rv[1]), .rsp_allow_o(ra[1]), .rsp_illegal_o(ri[1]),
    .rsp_virtual_o(rt[1]), .rsp_as_flush_o(rf[1]));

  cmo_perm_unit #(.MGMT_EN(1'b0), .ZERO_EN(1'b1)) u_dut_nm (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_wr_en_i(wr_en), .cfg_wr_sel_i(wr_sel),
    .cfg_wr_data_i(wr_data), .cfg_rd_sel_i(rd_sel), .cfg_rd_data_o(rd2),
    .req_valid_i(req_valid), .req_priv_i(req_priv), .req_virt_i(req_virt), .req_op_i(req_op),
    .rsp_valid_o(rv[2]), .rsp_allow_o(ra[2]), .rsp_illegal_o(ri[2]),
    .rsp_virtual_o(rt[2]), .rsp_as_flush_o(rf[2]));

  int    n_vec = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  bit    armed = 1'b0;
  string cur_req = "R1";

  int       shadow [3][3];   // [instance][level]
  bit [4:0] exp_q  [3];      // {valid, allow, illegal, virtual, flush}

  function automatic int mask_of(int k);
    if (k == 0) return 15;
    if (k == 1) return 7;
    return 8;
  endfunction

  function automatic int fld(int cfgv, int op);
    if (op <= 1) return cfgv & 1;
    if (op == 2) return (cfgv >> 1) & 3;
    return (cfgv >> 3) & 1;
  endfunction

  // behavioural model of the verdict rules
  function automatic bit [3:0] model(int m, int s, int h, int priv, bit virt, int op);
    int fm, fs, fh;
    bit machine, user, v, ill, vt, fl;
    fm = fld(m, op); fs = fld(s, op); fh = fld(h, op);
    machine = (priv == 3);
    user    = (priv == 0);
    if (machine) return 4'b1000;
    v   = virt;
    ill = (fm == 0) || (user && !v && fs == 0);
    vt  = 0;
    if (!ill && v && ((fh == 0) || (user && fs == 0))) vt = 1;
    fl = 0;
    if (!ill && !vt && op == 2)
      fl = (fm == 1) || (user && fs == 1) || (v && fh == 1);
    return {!ill && !vt, ill, vt, fl};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (armed) begin
      for (int k = 0; k < 3; k++) begin
        if (req_valid)
          exp_q[k] = {1'b1, model(shadow[k][0], shadow[k][1], shadow[k][2],
                                  int'(req_priv), req_virt, int'(req_op))};
        else
          exp_q[k] = 5'b0;
        if (wr_en && wr_sel != 2'd3)
          shadow[k][wr_sel] = int'(wr_data) & mask_of(k);
      end
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      for (int k = 0; k < 3; k++) begin
        n_vec++;
        if ({rv[k], ra[k], ri[k], rt[k], rf[k]} !== exp_q[k]) begin
          n_bad++;
          $display("FAIL %s inst%0d priv=%0d virt=%0d op=%0d got v/a/i/t/f=%b expected %b",
                   cur_req, k, req_priv, req_virt, req_op,
                   {rv[k], ra[k], ri[k], rt[k], rf[k]}, exp_q[k]);
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic do_wr(input int sel, input int data);
    @(negedge clk);
    req_valid = 1'b0;
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 4'(data);
  endtask

  task automatic do_req(input int p, input bit v, input int o);
    @(negedge clk);
    wr_en = 1'b0;
    req_valid = 1'b1; req_priv = 2'(p); req_virt = v; req_op = 2'(o);
  endtask

  task automatic do_idle();
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
  endtask

  task automatic rd_chk(input int sel);
    logic [3:0] got [3];
    int expv;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    rd_sel = 2'(sel);
    #1;
    got[0] = rd0; got[1] = rd1; got[2] = rd2;
    for (int k = 0; k < 3; k++) begin
      expv = (sel == 3) ? 0 : shadow[k][sel];
      n_vec++;
      if (int'(got[k]) != expv) begin
        n_bad++;
        $display("FAIL %s read inst%0d sel=%0d got %h expected %h", cur_req, k, sel, got[k], expv);
      end
    end
  endtask

  localparam int PAT [5] = '{0, 1, 3, 5, 15};

  initial begin
    rst_ni = 1'b0; wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 0;
    req_valid = 0; req_priv = 0; req_virt = 0; req_op = 0;
    for (int k = 0; k < 3; k++) begin
      exp_q[k] = 5'b0;
      for (int l = 0; l < 3; l++) shadow[k][l] = 0;
    end
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state of responses and configuration
    cur_req = "R1";
    for (int k = 0; k < 3; k++) begin
      n_vec++;
      if ({rv[k], ra[k], ri[k], rt[k], rf[k]} !== 5'b0) begin
        n_bad++;
        $display("FAIL R1 inst%0d response got %b expected 00000", k, {rv[k], ra[k], ri[k], rt[k], rf[k]});
      end
    end
    for (int s = 0; s < 4; s++) rd_chk(s);
    armed = 1'b1;

    // R2 and R3: write and read back, masks per variant, select 3 ignored
    cur_req = "R2 R3";
    do_wr(0, 11); do_wr(1, 6); do_wr(2, 13); do_wr(3, 15);
    for (int s = 0; s < 4; s++) rd_chk(s);
    do_wr(1, 15);
    rd_chk(1);

    // R4: idle cycles between requests give quiet outputs
    cur_req = "R4";
    do_req(1, 0, 0); do_idle(); do_req(0, 1, 2); do_idle(); do_idle();

    // R5 R6 R7 R8 R9 R10 R11: sweep of configurations and every request
    cur_req = "R5 R6 R7 R8 R9 R10 R11";
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 5; b++)
        for (int c = 0; c < 5; c++) begin
          do_wr(0, PAT[a]); do_wr(1, PAT[b]); do_wr(2, PAT[c]);
          for (int p = 0; p < 4; p++)
            for (int v = 0; v < 2; v++)
              for (int o = 0; o < 4; o++) do_req(p, v[0], o);
        end
    do_idle();

    // R10: invalidate field value 3 gives pure invalidate, value 1 at one level gives flush
    cur_req = "R10";
    do_wr(0, 6); do_wr(1, 6); do_wr(2, 6);
    do_req(0, 1, 2); do_req(1, 0, 2);
    do_wr(2, 2);
    do_req(1, 1, 2); do_req(0, 1, 2);
    do_idle();

    // R2: request in the same cycle as a write sees the old value
    cur_req = "R2";
    do_wr(0, 0);
    do_req(1, 0, 0);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 4'd15;
    req_valid = 1'b1; req_priv = 2'd1; req_virt = 1'b0; req_op = 2'd0;
    do_req(1, 0, 0);
    do_idle(); do_idle();
    rd_chk(0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule